// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between an internal synchronous bus master and an external asynchronous static RAM of 131,072 words by 8 bits. The master presents a single-word request: a 17-bit word address, a direction flag and, for stores, an 8-bit data byte. The controller turns that request into a timed pin sequence on the memory's address lines, its two chip selects (one active low, one active high), its write strobe, its output strobe and a split data bus. The split bus has a separate output value, output-enable and input value, so the pad ring can build the tristate buffer.

The cycle timing comes from three parameters: `RD_WAIT` is the number of clocks the read strobe stays active, `WR_WAIT` is the number of clocks the write strobe stays low, and `TURN_WAIT` is the number of recovery clocks after a read. These parameters let one design serve memories of different speed grades at any clock rate. A read returns its byte with a one-clock `rd_valid` pulse. `ready` is high only when a new request can be taken.

The sequencer has six states:
- `ST_IDLE`: standby; `ready` is high.
- `ST_RD_ACC`: chip selected with the output strobe low.
- `ST_RD_TURN`: standby recovery after a read.
- `ST_WR_SETUP`: chip selected with the driver on and the write strobe still high.
- `ST_WR_PULSE`: write strobe low.
- `ST_WR_HOLD`: write strobe raised again, with address and data still held.

The transitions are:
- IDLE to RD_ACC on a read request.
- IDLE to WR_SETUP on a write request.
- RD_ACC to RD_TURN when the read count expires, which is also when the data is captured.
- RD_TURN to IDLE when the recovery count expires.
- WR_SETUP to WR_PULSE after one clock.
- WR_PULSE to WR_HOLD when the write count expires.
- WR_HOLD to IDLE after one clock.

Top module: `sram_ctrl`

## Requirements
- R1: After reset and whenever `ready` is high, the memory is in standby and nothing drives the bus: `mem_ce1_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0.
- R2: A read accepted at a clock edge holds `mem_ce1_n`=0, `mem_ce2`=1, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0 for exactly `RD_WAIT` clocks, with `mem_addr` equal to the request address.
- R3: At the edge that ends the read strobe, `mem_dq_i` is registered into `rd_data`, and `rd_valid` is high for exactly the one following clock.
- R4: A write accepted at a clock edge gives, in order:
  - one setup clock with the chip selected, `mem_we_n`=1 and `mem_dq_oe`=1;
  - `WR_WAIT` clocks with `mem_we_n`=0;
  - one hold clock with `mem_we_n`=1 and the chip still selected;
  - then standby.
- R5: `mem_dq_oe` is never 1 while `mem_oe_n` is 0, and `mem_we_n` and `mem_oe_n` are never both 0.
- R6: After a read, the memory stays in standby with `ready` low for `TURN_WAIT` clocks (at least one) before the next request can be taken.
- R7: `ready` is low for the whole of an access. A request presented while `ready` is low is ignored: it changes neither the address nor the strobes of the access in progress, and it starts no access afterwards unless it is still present when `ready` is high.
- R8: During a write, `mem_addr` and `mem_dq_o` keep their values from the setup clock through the hold clock.
- R9: The two chip selects always change together: `mem_ce1_n` is the inverse of `mem_ce2` on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 17 | Word address of the request |
| req_wdata | input | 8 | Byte to store |
| ready | output | 1 | Controller idle, request accepted at this edge if valid |
| rd_valid | output | 1 | One-clock pulse marking `rd_data` valid |
| rd_data | output | 8 | Byte returned by the last load |
| mem_addr | output | 17 | Memory address lines |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output strobe |
| mem_dq_o | output | 8 | Data value to drive onto the memory bus |
| mem_dq_oe | output | 1 | Enable for the bus driver |
| mem_dq_i | input | 8 | Data value sampled from the memory bus |

## Verification
The bound checker checks the bus-safety properties on every clock:
- the driver never overlaps the output strobe;
- the two strobes are never low together;
- the chip selects stay complementary;
- standby is held while `ready` is high;
- address and data are held over the write strobe;
- `rd_valid` lasts a single clock.

The exact strobe lengths, the byte returned by a read, and the position of the turnaround clocks are shown only by the directed scenarios. Those scenarios count cycles against a memory model that latches data on the rising write strobe. The same applies to the fact that a request presented while busy is dropped.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_RD_TURN  = 3'd2,
        ST_WR_SETUP = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_WR_HOLD  = 3'd5
    } sram_state_e;

    typedef struct packed {
        logic ce1_n;
        logic ce2;
        logic we_n;
        logic oe_n;
        logic drv;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_STANDBY = '{ce1_n: 1'b1, ce2: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_ctrl_pkg::*;
#(
    parameter int RD_WAIT   = 3,
    parameter int WR_WAIT   = 3,
    parameter int TURN_WAIT = 1,
    parameter int CNT_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             tmr_dec,
    output logic             accept,
    output logic             capture,
    output logic             idle,
    output pin_ctl_t         pins
);
    localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_WAIT - 1);
    localparam logic [CNT_W-1:0] WR_LOAD   = CNT_W'(WR_WAIT - 1);
    localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN_WAIT - 1);

    sram_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tmr_dec  = 1'b0;
        accept   = 1'b0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (req_write) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d  = ST_RD_ACC;
                        tmr_load = 1'b1;
                        tmr_val  = RD_LOAD;
                    end
                end
            end
            ST_RD_ACC: begin
                if (tmr_zero) begin
                    capture  = 1'b1;
                    state_d  = ST_RD_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = TURN_LOAD;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_RD_TURN: begin
                if (tmr_zero) begin
                    state_d = ST_IDLE;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_WR_SETUP: begin
                state_d  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = WR_LOAD;
            end
            ST_WR_PULSE: begin
                if (tmr_zero) begin
                    state_d = ST_WR_HOLD;
                end else begin
                    tmr_dec = 1'b1;
                end
            end
            ST_WR_HOLD: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        pins = PINS_STANDBY;
        idle = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                idle = 1'b1;
            end
            ST_RD_ACC: begin
                pins.ce1_n = 1'b0;
                pins.ce2   = 1'b1;
                pins.oe_n  = 1'b0;
            end
            ST_RD_TURN: begin
                pins = PINS_STANDBY;
            end
            ST_WR_SETUP, ST_WR_HOLD: begin
                pins.ce1_n = 1'b0;
                pins.ce2   = 1'b1;
                pins.drv   = 1'b1;
            end
            ST_WR_PULSE: begin
                pins.ce1_n = 1'b0;
                pins.ce2   = 1'b1;
                pins.we_n  = 1'b0;
                pins.drv   = 1'b1;
            end
            default: begin
                pins = PINS_STANDBY;
            end
        endcase
    end
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= capture;
            if (capture) begin
                rdata_q <= mem_dq_i;
            end
        end
    end

    assign mem_addr = addr_q;
    assign mem_dq_o = wdata_q;
    assign rd_data  = rdata_q;
    assign rd_valid = rvalid_q;
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int RD_WAIT   = 3,
    parameter int WR_WAIT   = 3,
    parameter int TURN_WAIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int MAX_WAIT = (RD_WAIT > WR_WAIT)
                              ? ((RD_WAIT > TURN_WAIT) ? RD_WAIT : TURN_WAIT)
                              : ((WR_WAIT > TURN_WAIT) ? WR_WAIT : TURN_WAIT);
    localparam int CNT_W = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT);

    logic             tmr_load;
    logic             tmr_dec;
    logic             tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    logic             accept;
    logic             capture;
    logic             idle;
    pin_ctl_t         pins;

    sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .zero     (tmr_zero)
    );

    sram_seq #(
        .RD_WAIT   (RD_WAIT),
        .WR_WAIT   (WR_WAIT),
        .TURN_WAIT (TURN_WAIT),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .tmr_zero  (tmr_zero),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .tmr_dec   (tmr_dec),
        .accept    (accept),
        .capture   (capture),
        .idle      (idle),
        .pins      (pins)
    );

    sram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dq_i  (mem_dq_i),
        .mem_addr  (mem_addr),
        .mem_dq_o  (mem_dq_o),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    assign ready     = idle;
    assign mem_ce1_n = pins.ce1_n;
    assign mem_ce2   = pins.ce2;
    assign mem_we_n  = pins.we_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_dq_oe = pins.drv;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce1_n,
    input logic              mem_ce2,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_oe
);
    // R1
    idle_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe));

    // R3
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R4
    we_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce1_n && mem_dq_oe));

    // R5
    drv_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

    // R6
    turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (mem_ce1_n && !ready && rd_valid));

    // R7
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> !ready);

    // R8
    wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> ($stable(mem_addr) && $stable(mem_dq_o)));

    // R9
    ce_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce1_n == !mem_ce2);
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .ready     (ready),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_ce1_n (mem_ce1_n),
    .mem_ce2   (mem_ce2),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;
    localparam int AW = 17;
    localparam int DW = 8;
    localparam int RW = 3;
    localparam int WW = 3;
    localparam int TW = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          ready, rd_valid, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] rd_data, mem_dq_o, mem_dq_i;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] model [256];

    always #10 clk = ~clk;

    sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RD_WAIT(RW), .WR_WAIT(WW), .TURN_WAIT(TW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // memory model: latch on the rising write strobe, drive only in read mode
    always @(posedge mem_we_n) begin
        if (mem_ce1_n === 1'b0 && mem_ce2 === 1'b1) model[mem_addr[7:0]] <= mem_dq_o;
    end
    assign mem_dq_i = (!mem_ce1_n && mem_ce2 && mem_we_n && !mem_oe_n) ? model[mem_addr[7:0]] : 8'hEE;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset pins", {27'd0, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}, 32'b10110);
        chk("R1 reset ready", ready, 1);
        chk("R3 reset rd_valid", rd_valid, 0);
    endtask

    task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(posedge clk); @(negedge clk);
        req_valid = 0;
        chk("R4 setup pins", {27'd0, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}, 32'b01111);
        chk("R7 ready low in write", ready, 0);
        chk("R8 setup addr", mem_addr, a);
        chk("R8 setup data", mem_dq_o, d);
        for (int i = 0; i < WW; i++) begin
            @(negedge clk);
            chk("R4 we low", mem_we_n, 0);
            chk("R8 pulse addr", mem_addr, a);
            chk("R8 pulse data", mem_dq_o, d);
        end
        @(negedge clk);
        chk("R4 hold pins", {27'd0, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}, 32'b01111);
        chk("R8 hold addr", mem_addr, a);
        @(negedge clk);
        chk("R1 standby after write", {27'd0, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}, 32'b10110);
        chk("R1 ready after write", ready, 1);
        chk("R4 model stored", model[a[7:0]], d);
    endtask

    task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
        req_valid = 1; req_write = 0; req_addr = a;
        @(posedge clk); @(negedge clk);
        req_valid = 0;
        for (int i = 0; i < RW; i++) begin
            if (i > 0) @(negedge clk);
            chk("R2 read pins", {27'd0, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe}, 32'b01100);
            chk("R2 read addr", mem_addr, a);
            chk("R3 no early valid", rd_valid, 0);
        end
        @(negedge clk);
        chk("R3 valid pulse", rd_valid, 1);
        chk("R3 read data", rd_data, exp);
        chk("R6 standby in turn", {30'd0, mem_ce1_n, mem_oe_n}, 32'b11);
        chk("R6 ready low in turn", ready, 0);
        for (int i = 1; i < TW; i++) begin
            @(negedge clk);
            chk("R6 ready low in turn", ready, 0);
        end
        @(negedge clk);
        chk("R3 valid one clock", rd_valid, 0);
        chk("R6 ready after turn", ready, 1);
    endtask

    task automatic t_busy_ignore();
        req_valid = 1; req_write = 1; req_addr = 17'h00042; req_wdata = 8'h3C;
        @(posedge clk); @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 17'h1FF00;
        @(negedge clk);
        chk("R7 busy addr kept", mem_addr, 17'h00042);
        chk("R7 busy strobe kept", mem_oe_n, 1);
        repeat (WW) @(negedge clk);
        chk("R7 busy hold addr", mem_addr, 17'h00042);
        req_valid = 0;
        @(negedge clk);
        chk("R7 ready back", ready, 1);
        @(negedge clk);
        chk("R7 no stale access", {30'd0, mem_ce1_n, ready}, 32'b11);
        chk("R7 write still done", model[8'h42], 8'h3C);
    endtask

    task automatic t_cs_pair();
        chk("R9 chip selects complementary", mem_ce1_n, !mem_ce2);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'(i) ^ 8'h5A;
        repeat (3) @(posedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_read(17'h00010, 8'h10 ^ 8'h5A);
        t_write(17'h00010, 8'hA5);
        t_read(17'h00010, 8'hA5);
        t_write(17'h1FFFF, 8'h00);
        t_write(17'h00001, 8'hFF);
        t_read(17'h1FFFF, 8'h00);
        t_read(17'h00001, 8'hFF);
        t_busy_ignore();
        t_cs_pair();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule